// File: doc/BRIEF.md
# Narrowing Dual-Clock Stream Buffer

This block moves a continuous data stream from a host-side clock domain into a serial-transmit clock domain. On the host side it takes one 32-bit word per clock under a valid/ready handshake. On the transmit side it hands out one 16-bit half-word per clock under a second valid/ready handshake. Between the two sides is a dual-clock word store. Its write and read positions cross the clock boundary as Gray-coded counts through two-stage synchronizers.

The two clocks run at unrelated rates, so the buffer absorbs the difference in rate. It throttles the producer before the store can overflow: the write-side ready drops as soon as the free space, seen from the write side, shrinks to a programmable margin. That margin covers the cycles the producer needs to react. Each stored word leaves as two half-words, with the low half first. No half-word is lost, repeated or reordered.

Top module: `wnf_top`

## Requirements
- R1: A word on `wr_data` is stored on a rising `wr_clk` edge exactly when `wr_valid` and `wr_ready` are both 1.
- R2: The write-side level is the number of words stored minus the number of words whose two halves have both been taken, as seen from the write side. `wr_ready` is 1 only while this level is below `DEPTH - AF_SPACE`. The level never exceeds `DEPTH - AF_SPACE`. Starting from empty with reads stalled, exactly `DEPTH - AF_SPACE` words are accepted. `wr_ready` returns to 1 once the buffer drains.
- R3: Every stored word is delivered as two half-words: bits [15:0] first, then bits [31:16].
- R4: A half-word is taken on a rising `rd_clk` edge when `rd_valid` and `rd_ready` are both 1. While `rd_valid` is 1 and `rd_ready` is 0, both `rd_valid` and `rd_data` hold their values into the next cycle.
- R5: `rd_valid` is 0 whenever no half-word is stored. The half-words come out in exactly the order they were written, with none duplicated and none skipped.
- R6: While `wr_rst` is held, the write side empties and `wr_ready` reads 1 once it is released. While `rd_rst` is held, `rd_valid` reads 0.
- R7: The write and read position counts that cross domains change by at most one bit per clock of their own domain.
- R8: `wr_data` presented while `wr_valid` is 0, or while `wr_ready` is 0, is not stored and never appears at `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Host-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Buffer accepts a word (low when almost full) |
| wr_data | input | 32 | Word from producer |
| rd_clk | input | 1 | Transmit-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_valid | output | 1 | A half-word is presented |
| rd_ready | input | 1 | Consumer takes the half-word |
| rd_data | output | 16 | Half-word to consumer |

## Verification
The bench builds the block with `DEPTH = 16` and `AF_SPACE = 3`. With these values the throttle point of 13 words is reached within a few dozen write cycles, so a stalled read side shows the exact stop count. The smaller pointers also wrap many times during a run of a few hundred words, which exercises the Gray wrap-around in both directions. The write clock runs faster in bits per nanosecond than the read side can drain, so backpressure keeps recurring during the random phase while the model compares every half-word taken.

// File: rtl/wnf_pkg.sv
package wnf_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef struct packed {
        logic [HALF_W-1:0] upper;
        logic [HALF_W-1:0] lower;
    } word_t;

    typedef enum logic {
        SEL_LOWER = 1'b0,
        SEL_UPPER = 1'b1
    } half_sel_e;

    function automatic bit is_pow2(input int n);
        return (n > 1) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/wnf_gray_sync.sv
module wnf_gray_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage_a;
    logic [W-1:0] stage_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_a <= '0;
            stage_b <= '0;
        end else begin
            stage_a <= gray_in;
            stage_b <= stage_a;
        end
    end

    always_comb begin
        bin_out[W-1] = stage_b[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage_b[i];
        end
    end
endmodule

// File: rtl/wnf_store.sv
module wnf_store #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            wr_clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  wnf_pkg::word_t  wdata,
    input  logic [AW-1:0]   raddr,
    output wnf_pkg::word_t  rdata
);
    wnf_pkg::word_t cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/wnf_wr_side.sv
module wnf_wr_side #(
    parameter int DEPTH    = 64,
    parameter int AF_SPACE = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    output logic          ready,
    input  logic [PW-1:0] rbin_sync,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic [PW-1:0] level
);
    localparam logic [PW-1:0] STOP_LEVEL = PW'(DEPTH - AF_SPACE);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;

    assign level    = wbin - rbin_sync;
    assign ready    = (level < STOP_LEVEL);
    assign we       = valid && ready;
    assign waddr    = wbin[AW-1:0];
    assign wbin_nxt = wbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end
endmodule

// File: rtl/wnf_rd_side.sv
module wnf_rd_side #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ready,
    output logic               valid,
    input  logic [PW-1:0]      wbin_sync,
    output logic [PW-1:0]      rgray,
    output logic [AW-1:0]      raddr,
    output wnf_pkg::half_sel_e sel
);
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;
    logic          take;

    assign valid    = (rbin != wbin_sync);
    assign take     = valid && ready;
    assign raddr    = rbin[AW-1:0];
    assign rbin_nxt = rbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            sel   <= wnf_pkg::SEL_LOWER;
        end else if (take) begin
            if (sel == wnf_pkg::SEL_UPPER) begin
                rbin  <= rbin_nxt;
                rgray <= rbin_nxt ^ (rbin_nxt >> 1);
                sel   <= wnf_pkg::SEL_LOWER;
            end else begin
                sel   <= wnf_pkg::SEL_UPPER;
            end
        end
    end
endmodule

// File: rtl/wnf_top.sv
module wnf_top #(
    parameter int DEPTH    = 64,
    parameter int AF_SPACE = 4
) (
    input  logic        wr_clk,
    input  logic        wr_rst,
    input  logic        wr_valid,
    output logic        wr_ready,
    input  logic [31:0] wr_data,
    input  logic        rd_clk,
    input  logic        rd_rst,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic [15:0] rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    generate
        if (!wnf_pkg::is_pow2(DEPTH)) begin : g_bad_depth
            $error("DEPTH must be a power of two");
        end
        if (AF_SPACE < 1 || AF_SPACE >= DEPTH) begin : g_bad_margin
            $error("AF_SPACE must lie between 1 and DEPTH-1");
        end
    endgenerate

    logic [PW-1:0]      wgray;
    logic [PW-1:0]      rgray;
    logic [PW-1:0]      wbin_at_rd;
    logic [PW-1:0]      rbin_at_wr;
    logic [PW-1:0]      wr_level;
    logic [AW-1:0]      waddr;
    logic [AW-1:0]      raddr;
    logic               we;
    wnf_pkg::word_t     head_word;
    wnf_pkg::half_sel_e sel;

    wnf_wr_side #(.DEPTH(DEPTH), .AF_SPACE(AF_SPACE)) u_wr (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .valid     (wr_valid),
        .ready     (wr_ready),
        .rbin_sync (rbin_at_wr),
        .wgray     (wgray),
        .waddr     (waddr),
        .we        (we),
        .level     (wr_level)
    );

    wnf_gray_sync #(.W(PW)) u_sync_r2w (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .gray_in (rgray),
        .bin_out (rbin_at_wr)
    );

    wnf_gray_sync #(.W(PW)) u_sync_w2r (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .gray_in (wgray),
        .bin_out (wbin_at_rd)
    );

    wnf_store #(.DEPTH(DEPTH)) u_store (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wnf_pkg::word_t'(wr_data)),
        .raddr  (raddr),
        .rdata  (head_word)
    );

    wnf_rd_side #(.DEPTH(DEPTH)) u_rd (
        .clk       (rd_clk),
        .rst       (rd_rst),
        .ready     (rd_ready),
        .valid     (rd_valid),
        .wbin_sync (wbin_at_rd),
        .rgray     (rgray),
        .raddr     (raddr),
        .sel       (sel)
    );

    assign rd_data = (sel == wnf_pkg::SEL_UPPER) ? head_word.upper : head_word.lower;
endmodule

// File: rtl/wnf_chk.sv
module wnf_chk #(
    parameter int DEPTH    = 64,
    parameter int AF_SPACE = 4,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic [PW-1:0] wr_level,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [15:0]   rd_data
);
    assert_level_bound_R2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_level <= PW'(DEPTH - AF_SPACE));

    assert_stall_hold_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_wgray_step_R7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_rgray_step_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind wnf_top wnf_chk #(.DEPTH(DEPTH), .AF_SPACE(AF_SPACE)) u_chk (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .rd_clk   (rd_clk),
    .rd_rst   (rd_rst),
    .wr_level (wr_level),
    .wgray    (wgray),
    .rgray    (rgray),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data)
);

// File: tb/wnf_top_tb.sv
module wnf_top_tb;
    localparam int DEPTH    = 16;
    localparam int AF_SPACE = 3;
    localparam int STOP     = DEPTH - AF_SPACE;

    logic        wr_clk = 0;
    logic        rd_clk = 0;
    logic        wr_rst = 1;
    logic        rd_rst = 1;
    logic        wr_valid = 0;
    logic        wr_ready;
    logic [31:0] wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 0;
    logic [15:0] rd_data;

    always #3.5 wr_clk = ~wr_clk;
    always #2   rd_clk = ~rd_clk;

    wnf_top #(.DEPTH(DEPTH), .AF_SPACE(AF_SPACE)) u_dut (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_data  (wr_data),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready),
        .rd_data  (rd_data)
    );

    int          total = 0;
    int          bad = 0;
    int          words_in = 0;
    int          halves_out = 0;
    int          cyc = 0;
    logic [15:0] exp_q[$];
    bit          rd_go = 0;
    int          rd_pct = 70;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reader and reference comparison (R3 R4 R5)
    always @(negedge rd_clk) begin
        if (rd_rst) begin
            rd_ready = 0;
        end else begin
            rd_ready = rd_go && ($urandom_range(0, 99) < rd_pct);
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5 valid with nothing stored", 32'(rd_valid), 32'h0);
                end else if (rd_ready) begin
                    chk(rd_data == exp_q[0], "R3 R4 R5 half-word order", 32'(rd_data), 32'(exp_q[0]));
                    void'(exp_q.pop_front());
                    halves_out++;
                end
            end
        end
    end

    // Watchdog
    always @(posedge rd_clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "watchdog expired", 32'(cyc), 32'd150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // One write-side cycle; model pushes only accepted words (R1 R8)
    task automatic wr_cycle(input logic v, input logic [31:0] d, output bit took);
        @(negedge wr_clk);
        wr_valid = v;
        wr_data  = d;
        took = v && wr_ready;
        if (wr_ready) begin
            chk((words_in - halves_out / 2) < STOP, "R2 ready while level at limit",
                32'(words_in - halves_out / 2), 32'(STOP - 1));
        end
        if (took) begin
            exp_q.push_back(d[15:0]);
            exp_q.push_back(d[31:16]);
            words_in++;
        end
    endtask

    task automatic drain();
        bit t;
        int guard = 0;
        while (exp_q.size() != 0 && guard < 20000) begin
            wr_cycle(0, 32'hDEAD_BEEF, t);
            guard++;
        end
        for (int i = 0; i < 12; i++) wr_cycle(0, 32'hBAD0_0000 + 32'(i), t);
    endtask

    initial begin
        bit t;
        int acc;
        repeat (4) @(negedge wr_clk);
        @(negedge wr_clk) wr_rst = 0;
        @(negedge rd_clk) rd_rst = 0;
        repeat (3) @(negedge wr_clk);
        // R6 reset state
        chk(wr_ready == 1'b1, "R6 wr_ready after reset", 32'(wr_ready), 32'h1);
        chk(rd_valid == 1'b0, "R6 rd_valid after reset", 32'(rd_valid), 32'h0);

        // R3 low half presented first
        wr_cycle(1, 32'hA5A5_3C3C, t);
        chk(t == 1'b1, "R1 single word accepted", 32'(t), 32'h1);
        wr_cycle(0, 32'h0, t);
        repeat (10) @(negedge rd_clk);
        chk(rd_valid == 1'b1, "R3 word visible", 32'(rd_valid), 32'h1);
        chk(rd_data == 16'h3C3C, "R3 low half first", 32'(rd_data), 32'h3C3C);
        rd_go = 1;
        drain();
        chk(exp_q.size() == 0, "R5 both halves delivered", 32'(exp_q.size()), 32'h0);

        // R2 throttle with stalled reader; R8 data offered while not ready
        rd_go = 0;
        acc = 0;
        for (int i = 0; i < 60; i++) begin
            wr_cycle(1, 32'h1000_0000 + 32'(i * 3), t);
            if (t) acc++;
        end
        chk(acc == STOP, "R2 words accepted before stop", 32'(acc), 32'(STOP));
        @(negedge wr_clk);
        chk(wr_ready == 1'b0, "R2 ready low when almost full", 32'(wr_ready), 32'h0);
        wr_valid = 0;
        rd_go = 1;
        drain();
        chk(wr_ready == 1'b1, "R2 ready back after drain", 32'(wr_ready), 32'h1);
        chk(exp_q.size() == 0, "R8 no refused word delivered", 32'(exp_q.size()), 32'h0);

        // Random traffic with reader stalls
        acc = 0;
        while (acc < 400) begin
            wr_cycle($urandom_range(0, 9) < 8, $urandom, t);
            if (t) acc++;
        end
        rd_pct = 100;
        drain();
        chk(rd_valid == 1'b0, "R5 empty after random traffic", 32'(rd_valid), 32'h0);
        chk(wr_ready == 1'b1, "R2 ready after random traffic", 32'(wr_ready), 32'h1);
        chk(halves_out == 2 * words_in, "R5 no half skipped or repeated",
            32'(halves_out), 32'(2 * words_in));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule